// File: doc/BRIEF.md
# Serial Filter-Code Configuration Port

This block is a three-wire serial slave that keeps the 5-bit bandwidth code of an analog filter. An external controller pulls the frame strobe low and then clocks one mode bit on the serial clock. A mode bit of 1 starts a write, and a 0 starts a read. A write moves the next five data bits in, least significant bit first. The block applies the new code only when the frame strobe returns high. A read shifts the stored code out on the next five falling serial-clock edges, least significant bit first, and the code does not change.

The frame strobe, the serial clock and the serial data input are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block finds their edges from the synchronized samples. For this to work, the system clock must run at least four times faster than the serial clock. Next to the committed code, the block gives the decoded corner frequency in MHz for downstream logic. This value is the code plus one, and it saturates at 30.

Top module: `fcode_port`

## Requirements
- R1: Serial-clock edges are ignored while the frame strobe is high. A frame begins only after the frame strobe falls.
- R2: The first rising serial-clock edge of a frame samples the data input as the mode bit: 1 selects a write and 0 selects a read.
- R3: In a write, the next five rising serial-clock edges shift in the code. The first bit becomes bit 0 of the code.
- R4: The committed code changes only when the frame strobe rises after a write that received all five data bits. It then takes the shifted value.
- R5: In a read, each of the five falling serial-clock edges after the mode bit drives one bit of the stored code on the data output. Bit 0 comes first.
- R6: A read leaves the committed code unchanged.
- R7: For codes 0 through 29, the decoded frequency output equals the code plus one (1 to 30 MHz).
- R8: Codes 30 and 31 both decode to 30 MHz.
- R9: The data output is 0 whenever no read bit is being presented. This covers idle, writes, the mode bit, and the time after the fifth read bit.
- R10: If the frame strobe rises before all five data bits of a write have arrived, the frame is discarded and the committed code stays the same.
- R11: Serial-clock edges after the fifth data bit of a frame are ignored until the frame strobe rises.
- R12: After reset, the committed code is 0, the decoded frequency is 1 and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n_i | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data in (mode bit, then code) |
| sdout_o | output | 1 | Serial readback data |
| code_o | output | 5 | Committed filter code |
| corner_mhz_o | output | 5 | Decoded corner frequency in MHz |

## Verification
The assertions assume that the serial inputs change slowly enough for every level to last at least two system clocks after synchronization. They also assume that the data input is stable around each rising serial-clock edge. Because of this, the edge flags seen by the engine never overlap in a way that a real serial master could not produce. The stimulus holds each serial-clock phase for five system clocks. It changes data only while the serial clock is low, and it pulls the frame strobe low only while the serial clock is low. Under those conditions, the mode-bit edge is always the first edge seen in a frame.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int unsigned CODE_W_DEF  = 5;
  localparam int unsigned MAX_MHZ_DEF = 30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLAG,
    ST_WR,
    ST_WR_HOLD,
    ST_RD,
    ST_RD_HOLD
  } fcp_state_t;

  // Corner frequency: code plus one, clipped to the top setting.
  function automatic int unsigned corner_mhz(input int unsigned code,
                                             input int unsigned top);
    int unsigned f;
    f = code + 1;
    return (f > top) ? top : f;
  endfunction
endpackage

// File: rtl/fcp_sync.sv
module fcp_sync #(
  parameter int unsigned N       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES+1){RST_VAL[i]}};
      else        pipe <= {pipe[STAGES-1:0], async_i[i]};
    end
    assign level_o[i] = pipe[STAGES-1];
    assign rise_o[i]  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o[i]  = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/fcp_engine.sv
module fcp_engine
  import fcp_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_rise,
  input  logic              frame_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdin_s,
  output logic [CODE_W-1:0] code_o,
  output logic              sdout_o
);
  localparam int unsigned CNT_W = $clog2(CODE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  fcp_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] code_q;
  logic              sdo_q;

  // Named events for the assertions
  logic commit_w, abort_w;
  assign commit_w = frame_rise && (state == ST_WR_HOLD);
  assign abort_w  = frame_rise && (state == ST_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      code_q <= '0;
      sdo_q  <= 1'b0;
    end else if (frame_rise) begin
      if (state == ST_WR_HOLD) code_q <= shreg;
      state <= ST_IDLE;
      sdo_q <= 1'b0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (frame_fall) state <= ST_FLAG;
        ST_FLAG: if (sclk_rise) begin
          cnt   <= '0;
          shreg <= sdin_s ? '0 : code_q;
          state <= sdin_s ? ST_WR : ST_RD;
        end
        ST_WR: if (sclk_rise) begin
          shreg <= {sdin_s, shreg[CODE_W-1:1]};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_WR_HOLD;
        end
        ST_RD: if (sclk_fall) begin
          sdo_q <= shreg[0];
          shreg <= {1'b0, shreg[CODE_W-1:1]};
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_RD_HOLD;
        end
        ST_RD_HOLD: if (sclk_fall) sdo_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign code_o  = code_q;
  assign sdout_o = sdo_q;

  AST_CODE_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> $past(commit_w)); // R4
  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> $stable(code_q)); // R10
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD || state == ST_RD_HOLD) |=> $stable(code_q)); // R6
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_FLAG || state == ST_WR || state == ST_WR_HOLD)
      |-> !sdo_q); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CODE_W)); // R3
  AST_HOLD_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_HOLD && !frame_rise) |=> (state == ST_WR_HOLD) && $stable(shreg)); // R11
  AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !frame_fall) |=> (state == ST_IDLE)); // R1
endmodule

// File: rtl/fcp_decode.sv
module fcp_decode
  import fcp_pkg::*;
#(
  parameter int unsigned CODE_W  = CODE_W_DEF,
  parameter int unsigned MAX_MHZ = MAX_MHZ_DEF,
  parameter int unsigned MHZ_W   = $clog2(MAX_MHZ + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [MHZ_W-1:0]  mhz_o
);
  always_comb mhz_o = MHZ_W'(corner_mhz(int'(code_i), MAX_MHZ));
endmodule

// File: rtl/fcode_port.sv
module fcode_port
  import fcp_pkg::*;
#(
  parameter int unsigned CODE_W  = CODE_W_DEF,
  parameter int unsigned MAX_MHZ = MAX_MHZ_DEF,
  parameter int unsigned STAGES  = 2,
  localparam int unsigned MHZ_W  = $clog2(MAX_MHZ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  output logic [CODE_W-1:0] code_o,
  output logic [MHZ_W-1:0]  corner_mhz_o
);
  // bit 2: frame strobe, bit 1: serial clock, bit 0: data
  logic [2:0] lvl, rise, fall;

  fcp_sync #(.N(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({frame_n_i, sclk_i, sdin_i}),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  fcp_engine #(.CODE_W(CODE_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .frame_rise(rise[2]), .frame_fall(fall[2]),
    .sclk_rise(rise[1]), .sclk_fall(fall[1]),
    .sdin_s(lvl[0]),
    .code_o(code_o), .sdout_o(sdout_o)
  );

  fcp_decode #(.CODE_W(CODE_W), .MAX_MHZ(MAX_MHZ), .MHZ_W(MHZ_W)) u_dec (
    .code_i(code_o), .mhz_o(corner_mhz_o)
  );

  AST_MHZ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    corner_mhz_o >= MHZ_W'(1) && corner_mhz_o <= MHZ_W'(MAX_MHZ)); // R8
  AST_MHZ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(code_o) < MAX_MHZ) |-> (int'(corner_mhz_o) == int'(code_o) + 1)); // R7
endmodule

// File: tb/fcode_port_test.sv
module fcode_port_test;
  localparam int HP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdout;
  logic [4:0] code, mhz;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fcode_port uut (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .sclk_i(sclk),
    .sdin_i(sdin), .sdout_o(sdout), .code_o(code), .corner_mhz_o(mhz)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit lq[$], cq[$], dq[$];
  int mst, mcnt, macc, mcode;
  bit msdo;

  function automatic int ref_mhz(input int c);
    if (c >= 29) return 30;
    return c + 1;
  endfunction

  always @(posedge clk) begin
    bit lc, lp, sc, sp, d;
    if (!rst_n) begin
      lq = {1, 1, 1, 1}; cq = {0, 0, 0, 0}; dq = {0, 0, 0, 0};
      mst = 0; mcnt = 0; macc = 0; mcode = 0; msdo = 0;
    end else begin
      lq.push_back(frame_n); void'(lq.pop_front());
      cq.push_back(sclk);    void'(cq.pop_front());
      dq.push_back(sdin);    void'(dq.pop_front());
      lc = lq[1]; lp = lq[0]; sc = cq[1]; sp = cq[0]; d = dq[1];
      if (lc && !lp) begin
        if (mst == 2 && mcnt == 5) mcode = macc;
        mst = 0; msdo = 0;
      end else begin
        case (mst)
          0: if (!lc && lp) mst = 1;
          1: if (sc && !sp) begin mst = d ? 2 : 3; mcnt = 0; macc = 0; end
          2: if (sc && !sp && mcnt < 5) begin macc += int'(d) << mcnt; mcnt++; end
          3: if (!sc && sp) begin
               if (mcnt < 5) begin msdo = mcode[mcnt]; mcnt++; end
               else msdo = 0;
             end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R4 code vs model", code, mcode);
    chk("R7 R8 mhz vs model", mhz, ref_mhz(mcode));
    chk("R5 R9 sdout vs model", sdout, msdo);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; wait_n(HP);
    sclk = 1'b0; wait_n(HP);
  endtask

  task automatic write_frame(input logic [4:0] v, input int nbits);
    frame_n = 1'b0; wait_n(HP);
    sdin = 1'b1; wait_n(1); pulse();
    for (int b = 0; b < nbits; b++) begin
      sdin = (b < 5) ? v[b] : 1'b1; wait_n(1); pulse();
    end
    sdin = 1'b0;
    frame_n = 1'b1; wait_n(3 * HP);
  endtask

  task automatic read_frame(output logic [4:0] v, input int extra);
    frame_n = 1'b0; wait_n(HP);
    sdin = 1'b0; wait_n(1);
    for (int b = 0; b < 5; b++) begin
      sclk = 1'b1; wait_n(HP);
      sclk = 1'b0; wait_n(HP);
      v[b] = sdout;
    end
    for (int e = 0; e < extra; e++) begin
      pulse();
      chk("R9 sdout low after fifth read bit", sdout, 0);
    end
    frame_n = 1'b1; wait_n(3 * HP);
    chk("R9 sdout low after read", sdout, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] rb;
    wait_n(4);
    chk("R12 reset code", code, 0);
    chk("R12 reset mhz", mhz, 1);
    chk("R12 reset sdout", sdout, 0);
    rst_n = 1'b1;
    wait_n(4);

    // R1: edges with the strobe high do nothing
    sdin = 1'b1;
    for (int i = 0; i < 6; i++) pulse();
    sdin = 1'b0; wait_n(HP);
    chk("R1 code unchanged with strobe high", code, 0);
    chk("R1 sdout quiet with strobe high", sdout, 0);

    // R2 R3 R4: plain write, then read back
    write_frame(5'd5, 5);
    chk("R3 R4 write 5", code, 5);
    chk("R7 mhz for 5", mhz, 6);
    read_frame(rb, 0);
    chk("R2 R5 readback 5", rb, 5);
    chk("R6 code after read", code, 5);

    write_frame(5'b10110, 5);
    chk("R3 LSB-first write 22", code, 22);
    read_frame(rb, 2);
    chk("R5 readback 22", rb, 22);
    chk("R6 code after read with extra edges", code, 22);

    write_frame(5'd29, 5);
    chk("R7 mhz for 29", mhz, 30);
    write_frame(5'd30, 5);
    chk("R8 mhz for 30", mhz, 30);
    write_frame(5'd31, 5);
    chk("R8 mhz for 31", mhz, 30);
    read_frame(rb, 0);
    chk("R5 readback 31", rb, 31);
    write_frame(5'd0, 5);
    chk("R7 mhz for 0", mhz, 1);

    // R10: short write is dropped
    write_frame(5'd9, 5);
    write_frame(5'd3, 3);
    chk("R10 short write discarded", code, 9);
    write_frame(5'd12, 0);
    chk("R10 flag-only write discarded", code, 9);

    // R11: edges beyond the fifth bit are ignored
    write_frame(5'd17, 8);
    chk("R11 extra edges ignored", code, 17);
    read_frame(rb, 0);
    chk("R11 readback after long write", rb, 17);

    for (int c = 0; c < 32; c += 7) begin
      write_frame(c[4:0], 5);
      chk("R7 R8 sweep mhz", mhz, (c >= 29) ? 30 : c + 1);
    end

    wait_n(10);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule